// File: doc/BRIEF.md
# T1 Superframe Alignment with Mimic Detection

This block takes a recovered T1 bitstream, one bit per strobe, organised as 193-bit frames whose first bit is an overhead bit. It finds both the frame boundary and the superframe phase. Two formats are supported: the 12-frame superframe and the 24-frame extended superframe, selected by a static mode input. Every one of the 193 bit positions is treated as a possible overhead bit. For each position, a shift history of the bits seen there in past frames is kept. The first position whose history fits two consecutive superframes of the expected framing pattern becomes the candidate. The rest of that frame is then watched for a second position that also fits, which marks a mimic. At the end of that frame, sync is declared on the candidate.

Once in sync, the block runs bit and frame counters. It checks each framing bit and pulses an error on any mismatch. It drops sync on a burst of framing errors. A force input lets surrounding logic restart the hunt at any time. CRC checking, data link extraction and line decoding belong to other blocks.

Top module: `t1_sf_align`

## Requirements
- R1: In 12-frame mode every overhead bit is a framing bit. By frame index 0..11 (index 0 is the first frame of the superframe), the expected values are 1,0,0,0,1,1,0,1,1,1,0,0.
- R2: In 24-frame mode only the overhead bits of frame indices 3,7,11,15,19,23 are checked, expecting 0,0,1,0,1,1. The overhead bits of all other frames are neither checked nor counted, so corrupting them raises no error.
- R3: `in_sync` rises on the strobe of the last bit (bit index 192) of the frame that completes the second consecutive matching superframe at the winning position. At that point `bit_cnt` is 192 and `frame_cnt` is the last frame index (11 or 23). It is 0 one frame earlier.
- R4: While in sync, every strobe advances `bit_cnt` modulo 193; bit index 0 is the overhead bit. `frame_cnt` advances modulo 12 or 24 when `bit_cnt` wraps to 0. Neither counter changes in a cycle without a strobe.
- R5: `mimic` is set at sync declaration when a second bit position also fitted the pattern during the frame between first fit and declaration.
- R6: `mimic` changes only when sync is declared. It keeps its value through a later hunt and is cleared by a resync that sees only one fitting position.
- R7: While in sync, a checked framing bit that differs from its expected value makes `fbit_err` high for exactly one clock, the clock after its strobe.
- R8: A single framing error leaves sync in place. So do errors 4 checked framing bits apart. A second error within 4 consecutive checked framing bits clears `in_sync` on that strobe.
- R9: A pulse on `force_reframe` clears `in_sync` on the next strobe and restarts the hunt. Sync is declared again on the next superframe whose history still fits.
- R10: After reset, `in_sync`, `mimic`, `fbit_err`, `bit_cnt` and `frame_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Strobe: `bit_in` is valid this cycle |
| bit_in | input | 1 | Recovered line bit |
| esf_mode | input | 1 | 0: 12-frame superframe, 1: 24-frame extended superframe (static) |
| force_reframe | input | 1 | Drop sync and restart the hunt at the next strobe |
| in_sync | output | 1 | Frame and superframe alignment established |
| mimic | output | 1 | More than one position fitted during the last sync hunt |
| fbit_err | output | 1 | One-clock pulse per framing-bit error while in sync |
| bit_cnt | output | 8 | Bit index within the frame, 0 = overhead bit |
| frame_cnt | output | 5 | Frame index within the superframe, 0-based |

## Verification
All results are registered on the clock edge that accepts a strobe. `in_sync`, `mimic`, `bit_cnt` and `frame_cnt` therefore carry the new values from that edge on, and `fbit_err` is high only in the clock that follows a framing-bit strobe. The bench holds the strobe for one clock and leaves a one-clock gap after it. It samples outputs at the falling edge right after each strobe, where counters, sync and the error pulse are due. It samples again at the falling edge in the gap, where the pulse must already be gone. Sync and mimic are checked at the end of whole frames, counted by the bench from reset, so the exact frame of declaration is pinned down.

// File: rtl/t1fa_pkg.sv
package t1fa_pkg;

  localparam int SF_SHORT = 12;
  localparam int SF_LONG  = 24;
  localparam int FRM_W    = 5;

  // Overhead bit is checked in this frame (index 0-based within superframe)
  function automatic logic fb_care(input logic esf, input logic [FRM_W-1:0] f);
    return esf ? (f[1:0] == 2'd3) : 1'b1;
  endfunction

  // Expected framing value for a checked frame index
  function automatic logic fb_expect(input logic esf, input logic [FRM_W-1:0] f);
    logic r;
    r = 1'b0;
    if (esf) begin
      case (f)
        5'd11, 5'd19, 5'd23: r = 1'b1;
        default:             r = 1'b0;
      endcase
    end else begin
      case (f)
        5'd0, 5'd4, 5'd5, 5'd7, 5'd8, 5'd9: r = 1'b1;
        default:                            r = 1'b0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/t1fa_hist_mem.sv
module t1fa_hist_mem #(
  parameter int FRAME_BITS = 193,
  parameter int CONFIRM_SF = 2,
  localparam int POS_W  = $clog2(FRAME_BITS),
  localparam int HIST_W = CONFIRM_SF * t1fa_pkg::SF_LONG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              esf,
  output logic [POS_W-1:0]  pos,
  output logic [HIST_W-1:0] hist_new,
  output logic              filled
);
  localparam int FILL_W   = $clog2(HIST_W + 1);
  localparam int NEED_S   = CONFIRM_SF * t1fa_pkg::SF_SHORT - 1;
  localparam int NEED_L   = HIST_W - 1;

  logic [HIST_W-1:0] mem_q [FRAME_BITS];
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              last_pos;

  assign last_pos = (pos_q == POS_W'(FRAME_BITS - 1));
  assign hist_new = {mem_q[pos_q][HIST_W-2:0], bit_in};
  assign filled   = esf ? (fill_q >= FILL_W'(NEED_L)) : (fill_q >= FILL_W'(NEED_S));
  assign pos      = pos_q;

  always_comb begin
    pos_d  = pos_q;
    fill_d = fill_q;
    if (bit_en) begin
      pos_d = last_pos ? '0 : pos_q + 1'b1;
      if (last_pos && (fill_q < FILL_W'(NEED_L))) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      fill_q <= '0;
    end else begin
      pos_q  <= pos_d;
      fill_q <= fill_d;
    end
  end

  // History storage: one entry per candidate position, no reset
  always_ff @(posedge clk) begin
    if (bit_en) mem_q[pos_q] <= hist_new;
  end

  // R4
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> $stable(pos_q));

endmodule

// File: rtl/t1fa_pattern_chk.sv
module t1fa_pattern_chk #(
  parameter int CONFIRM_SF = 2,
  localparam int HIST_W = CONFIRM_SF * t1fa_pkg::SF_LONG,
  localparam int SHORT_W = CONFIRM_SF * t1fa_pkg::SF_SHORT
) (
  input  logic [HIST_W-1:0] hist,
  input  logic              esf,
  output logic              match
);
  import t1fa_pkg::*;

  logic [HIST_W-1:0] hit_long;
  logic [HIST_W-1:0] hit_short;

  // hist[0] is the newest bit and sits in the last frame of a superframe
  for (genvar k = 0; k < HIST_W; k++) begin : g_hit
    localparam int FL = SF_LONG - 1 - (k % SF_LONG);
    localparam int FS = SF_SHORT - 1 - (k % SF_SHORT);
    assign hit_long[k]  = !fb_care(1'b1, FRM_W'(FL)) ||
                          (hist[k] == fb_expect(1'b1, FRM_W'(FL)));
    if (k < SHORT_W) begin : g_s
      assign hit_short[k] = (hist[k] == fb_expect(1'b0, FRM_W'(FS)));
    end else begin : g_n
      assign hit_short[k] = 1'b1;
    end
  end

  assign match = esf ? (&hit_long) : (&hit_short);

endmodule

// File: rtl/t1fa_sync_fsm.sv
module t1fa_sync_fsm #(
  parameter int FRAME_BITS = 193,
  parameter int ERR_WIN    = 4,
  parameter int ERR_LIMIT  = 2,
  localparam int POS_W = $clog2(FRAME_BITS),
  localparam int EH_W  = ERR_WIN - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bit_en,
  input  logic                      bit_in,
  input  logic                      esf,
  input  logic                      force_reframe,
  input  logic                      match,
  input  logic                      filled,
  output logic                      in_sync,
  output logic                      mimic,
  output logic                      fbit_err,
  output logic [POS_W-1:0]          bit_cnt,
  output logic [t1fa_pkg::FRM_W-1:0] frame_cnt
);
  import t1fa_pkg::*;

  typedef enum logic [1:0] {ST_HUNT, ST_CONFIRM, ST_SYNC} st_e;

  st_e              state_q, state_d;
  logic [POS_W-1:0] win_q, win_d;
  logic [POS_W-1:0] bit_q, bit_d, bit_inc;
  logic [FRM_W-1:0] frm_q, frm_d, frm_inc, sf_last;
  logic             seen_q, seen_d;
  logic             mimic_q, mimic_d;
  logic             err_q, err_d;
  logic             pend_q, pend_d;
  logic [EH_W-1:0]  eh_q, eh_d;
  logic [EH_W:0]    eh_ext;
  logic             mis;

  assign sf_last = esf ? FRM_W'(SF_LONG - 1) : FRM_W'(SF_SHORT - 1);
  assign bit_inc = (bit_q == POS_W'(FRAME_BITS - 1)) ? '0 : bit_q + 1'b1;
  assign frm_inc = (bit_inc != '0) ? frm_q : ((frm_q == sf_last) ? '0 : frm_q + 1'b1);
  assign mis     = (bit_in != fb_expect(esf, frm_inc));
  assign eh_ext  = {eh_q, mis};

  always_comb begin
    state_d = state_q;
    win_d   = win_q;
    bit_d   = bit_q;
    frm_d   = frm_q;
    seen_d  = seen_q;
    mimic_d = mimic_q;
    eh_d    = eh_q;
    err_d   = 1'b0;
    pend_d  = pend_q | force_reframe;
    if (bit_en) begin
      if (pend_q || force_reframe) begin
        state_d = ST_HUNT;
        pend_d  = 1'b0;
        bit_d   = '0;
        frm_d   = '0;
        seen_d  = 1'b0;
        eh_d    = '0;
      end else begin
        unique case (state_q)
          ST_HUNT: begin
            if (filled && match) begin
              state_d = ST_CONFIRM;
              win_d   = '0;
              seen_d  = 1'b0;
            end
          end
          ST_CONFIRM: begin
            if (match) seen_d = 1'b1;
            if (win_q == POS_W'(FRAME_BITS - 2)) begin
              state_d = ST_SYNC;
              mimic_d = seen_q | match;
              bit_d   = POS_W'(FRAME_BITS - 1);
              frm_d   = sf_last;
              eh_d    = '0;
            end else begin
              win_d = win_q + 1'b1;
            end
          end
          ST_SYNC: begin
            bit_d = bit_inc;
            frm_d = frm_inc;
            if ((bit_inc == '0) && fb_care(esf, frm_inc)) begin
              err_d = mis;
              eh_d  = eh_ext[EH_W-1:0];
              if (mis && (int'($countones(eh_ext)) >= ERR_LIMIT)) begin
                state_d = ST_HUNT;
                bit_d   = '0;
                frm_d   = '0;
                seen_d  = 1'b0;
                eh_d    = '0;
              end
            end
          end
          default: state_d = ST_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      win_q   <= '0;
      bit_q   <= '0;
      frm_q   <= '0;
      seen_q  <= 1'b0;
      mimic_q <= 1'b0;
      err_q   <= 1'b0;
      pend_q  <= 1'b0;
      eh_q    <= '0;
    end else begin
      state_q <= state_d;
      win_q   <= win_d;
      bit_q   <= bit_d;
      frm_q   <= frm_d;
      seen_q  <= seen_d;
      mimic_q <= mimic_d;
      err_q   <= err_d;
      pend_q  <= pend_d;
      eh_q    <= eh_d;
    end
  end

  assign in_sync   = (state_q == ST_SYNC);
  assign mimic     = mimic_q;
  assign fbit_err  = err_q;
  assign bit_cnt   = bit_q;
  assign frame_cnt = frm_q;

  // R7
  err_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fbit_err |-> ($past(state_q == ST_SYNC) && $past(bit_en)));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> ($stable(bit_q) && $stable(frm_q)));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q < POS_W'(FRAME_BITS)) && (frm_q <= sf_last));

  // R6
  mimic_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mimic_q) |-> $rose(in_sync));

  // R3
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> ((bit_q == POS_W'(FRAME_BITS - 1)) && (frm_q == sf_last)
                        && $past(state_q == ST_CONFIRM)));

  // R8
  sync_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> (fbit_err || $past(pend_q || force_reframe)));

endmodule

// File: rtl/t1_sf_align.sv
module t1_sf_align #(
  parameter int FRAME_BITS = 193,
  parameter int CONFIRM_SF = 2,
  parameter int ERR_WIN    = 4,
  parameter int ERR_LIMIT  = 2,
  localparam int POS_W  = $clog2(FRAME_BITS),
  localparam int HIST_W = CONFIRM_SF * t1fa_pkg::SF_LONG
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_en,
  input  logic                       bit_in,
  input  logic                       esf_mode,
  input  logic                       force_reframe,
  output logic                       in_sync,
  output logic                       mimic,
  output logic                       fbit_err,
  output logic [POS_W-1:0]           bit_cnt,
  output logic [t1fa_pkg::FRM_W-1:0] frame_cnt
);
  logic [1:0]        rsync_q;
  logic              rst_int_n;
  logic [POS_W-1:0]  pos;
  logic [HIST_W-1:0] hist_new;
  logic              filled;
  logic              match;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  t1fa_hist_mem #(.FRAME_BITS(FRAME_BITS), .CONFIRM_SF(CONFIRM_SF)) u_hist (
    .clk(clk), .rst_n(rst_int_n), .bit_en(bit_en), .bit_in(bit_in),
    .esf(esf_mode), .pos(pos), .hist_new(hist_new), .filled(filled)
  );

  t1fa_pattern_chk #(.CONFIRM_SF(CONFIRM_SF)) u_pat (
    .hist(hist_new), .esf(esf_mode), .match(match)
  );

  t1fa_sync_fsm #(.FRAME_BITS(FRAME_BITS), .ERR_WIN(ERR_WIN), .ERR_LIMIT(ERR_LIMIT)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .bit_en(bit_en), .bit_in(bit_in),
    .esf(esf_mode), .force_reframe(force_reframe), .match(match), .filled(filled),
    .in_sync(in_sync), .mimic(mimic), .fbit_err(fbit_err),
    .bit_cnt(bit_cnt), .frame_cnt(frame_cnt)
  );

  // R4: while in sync the frame counter keeps a fixed offset to the
  // history write position
  sync_offset_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_sync && $past(in_sync)) |->
      (((int'(pos) - int'(bit_cnt) + FRAME_BITS) % FRAME_BITS) ==
       (($past(int'(pos)) - $past(int'(bit_cnt)) + FRAME_BITS) % FRAME_BITS)));

endmodule

// File: tb/t1_sf_align_bench.sv
module t1_sf_align_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 193;
  localparam int MIMIC_POS  = 100;
  localparam int WATCHDOG   = 190000;

  // Scenario table: {esf_mode, mimic copy enabled}; mimic expected = bit 0
  localparam logic [1:0] SCEN_TAB [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
  // R1 expected overhead bits by frame index, R2 expected pattern bits
  localparam logic [0:11] SHORT_SEQ = 12'b1000_1101_1100;
  localparam logic [0:5]  LONG_SEQ  = 6'b001011;

  logic clk, rst_n, bit_en, bit_in, esf_mode, force_reframe;
  logic in_sync, mimic, fbit_err;
  logic [7:0] bit_cnt;
  logic [4:0] frame_cnt;

  int checks = 0;
  int failures = 0;
  int err_cycles = 0;
  int tf = 0;
  int sf_len = 12;
  logic mim_b = 1'b0;
  logic fb_sync;
  logic [7:0] fb_bit;
  logic [4:0] fb_frm;

  t1_sf_align u_t1_sf_align (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .esf_mode(esf_mode), .force_reframe(force_reframe),
    .in_sync(in_sync), .mimic(mimic), .fbit_err(fbit_err),
    .bit_cnt(bit_cnt), .frame_cnt(frame_cnt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic exp_fbit(input int f);
    if (esf_mode) return (f % 4 == 3) ? LONG_SEQ[f/4] : f[0];
    return SHORT_SEQ[f];
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    if (fbit_err) err_cycles++;
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    if (fbit_err) err_cycles++;
  endtask

  task automatic send_frame(input logic flip);
    logic fb;
    fb = exp_fbit(tf);
    send_bit(fb ^ flip);
    fb_sync = in_sync;
    fb_bit  = bit_cnt;
    fb_frm  = frame_cnt;
    for (int i = 1; i < FRAME_BITS; i++)
      send_bit((mim_b && i == MIMIC_POS) ? fb : 1'b0);
    tf = (tf + 1) % sf_len;
  endtask

  task automatic do_reset(input logic esf, input logic mim);
    rst_n = 1'b0;
    bit_en = 1'b0;
    bit_in = 1'b0;
    force_reframe = 1'b0;
    esf_mode = esf;
    mim_b = mim;
    sf_len = esf ? 24 : 12;
    tf = 0;
    err_cycles = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R10: reset state
    do_reset(1'b0, 1'b0);
    chk(in_sync == 0,   "R10 in_sync", in_sync, 0);
    chk(mimic == 0,     "R10 mimic", mimic, 0);
    chk(fbit_err == 0,  "R10 fbit_err", fbit_err, 0);
    chk(bit_cnt == 0,   "R10 bit_cnt", bit_cnt, 0);
    chk(frame_cnt == 0, "R10 frame_cnt", frame_cnt, 0);

    // Table-driven acquisition in both formats, with and without mimic
    for (int s = 0; s < 4; s++) begin
      logic esf, mexp;
      esf  = SCEN_TAB[s][1];
      mexp = SCEN_TAB[s][0];
      do_reset(esf, mexp);
      for (int f = 0; f < 2*sf_len - 1; f++) send_frame(1'b0);
      chk(in_sync == 0, "R3 not yet in sync", in_sync, 0);
      send_frame(1'b0);
      chk(in_sync == 1, "R3 in sync after two superframes", in_sync, 1);
      chk(bit_cnt == 192, "R3 bit_cnt at declaration", bit_cnt, 192);
      chk(frame_cnt == sf_len - 1, "R3 frame_cnt at declaration", frame_cnt, sf_len - 1);
      chk(mimic == mexp, "R5 mimic at declaration", mimic, mexp);
      err_cycles = 0;
      for (int f = 0; f < sf_len; f++) begin
        // R2: in long mode corrupt a non-pattern bit (frame 0) and a pattern bit (frame 3)
        send_frame(esf && (f == 0 || f == 3));
        chk(fb_bit == 0 && fb_frm == f, esf ? "R2 R4 counters at overhead bit" : "R1 R4 counters at overhead bit",
            fb_frm, f);
        chk(fb_sync == 1, esf ? "R2 stays in sync" : "R1 stays in sync", fb_sync, 1);
      end
      chk(err_cycles == (esf ? 1 : 0), esf ? "R2 only pattern bit flagged" : "R1 no error on clean pattern",
          err_cycles, esf ? 1 : 0);
    end

    // R4: counters hold without a strobe
    begin
      logic [7:0] hb;
      logic [4:0] hf;
      hb = bit_cnt;
      hf = frame_cnt;
      repeat (3) @(negedge clk);
      chk(bit_cnt == hb && frame_cnt == hf, "R4 counters hold between strobes", bit_cnt, hb);
    end

    // R7, R8: error pulse and error-burst loss of sync (short format)
    do_reset(1'b0, 1'b0);
    for (int f = 0; f < 24; f++) send_frame(1'b0);
    err_cycles = 0;
    send_frame(1'b1);
    chk(err_cycles == 1, "R7 single one-clock pulse", err_cycles, 1);
    chk(in_sync == 1, "R8 single error keeps sync", in_sync, 1);
    for (int f = 0; f < 3; f++) send_frame(1'b0);
    send_frame(1'b1);
    chk(err_cycles == 2, "R7 second pulse", err_cycles, 2);
    chk(in_sync == 1, "R8 errors four bits apart keep sync", in_sync, 1);
    send_frame(1'b0);
    send_frame(1'b1);
    chk(fb_sync == 0, "R8 second error in window drops sync", fb_sync, 0);
    chk(err_cycles == 3, "R7 pulse on losing error", err_cycles, 3);

    // R9, R6: force reframe, mimic held through hunt and cleared at resync
    do_reset(1'b0, 1'b1);
    for (int f = 0; f < 24; f++) send_frame(1'b0);
    chk(mimic == 1, "R5 mimic set", mimic, 1);
    mim_b = 1'b0;
    @(negedge clk);
    force_reframe = 1'b1;
    @(negedge clk);
    force_reframe = 1'b0;
    chk(in_sync == 1, "R9 sync kept until strobe", in_sync, 1);
    send_frame(1'b0);
    chk(fb_sync == 0, "R9 sync cleared on next strobe", fb_sync, 0);
    chk(mimic == 1, "R6 mimic held during hunt", mimic, 1);
    for (int f = 1; f < 11; f++) send_frame(1'b0);
    chk(in_sync == 0, "R9 not yet resynced", in_sync, 0);
    send_frame(1'b0);
    chk(in_sync == 1, "R9 resync at superframe end", in_sync, 1);
    chk(mimic == 0, "R6 mimic cleared on clean resync", mimic, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule